// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block controls the power-down state of a small microcontroller core. A one-cycle sleep strobe from the core's decoder clears the watchdog, records the power-down in the status bits, switches the oscillator driver off and stalls the core. The controller then waits for one of three wake causes: the active-low external reset pin, a watchdog time-out (only while the watchdog is enabled), or any interrupt source whose flag and individual enable are both set. The global interrupt enable plays no part in waking.

On wake the oscillator is switched back on. In crystal mode the controller counts a start-up delay of `STARTUP_CYC` clocks before execution resumes. In RC mode that delay is skipped. A reset-pin wake is a full device reset. A watchdog or interrupt wake continues in-line. After an interrupt wake with the global enable set, the core runs the next instruction, then takes one dummy cycle, and then receives a vector request that sends it to address 0x0004. The time-out and power-down status bits let software tell these cases apart.

Top module: `pwrdown_ctl`

## Requirements
- R1: After power-on reset (`rst_n` low), `stat_to`=1, `stat_pd`=1, `osc_en`=1, `core_stall`=0, `vec_req`=0, `wdt_clr`=0 and `core_rst`=0 (pin high).
- R2: A `slp_req` strobe while running, with no interrupt pending, gives the following in the cycle after the strobe: `wdt_clr` high for exactly one cycle, `stat_pd`=0, `stat_to`=1, `osc_en`=0 and `core_stall`=1.
- R3: During sleep, only three events wake the core: `rstpin_n`=0, `wdt_to`=1 together with `wdt_en`=1, or a bit i with `irq_flag[i]`=1 and `irq_en[i]`=1. The core stays asleep (`osc_en`=0) on a time-out with `wdt_en`=0, on a flag whose enable is 0, or on any value of `gie`.
- R4: Every wake, whatever its cause, gives the following in the cycle after the waking event: `osc_en`=1 and a one-cycle `wdt_clr` pulse.
- R5: A watchdog wake clears `stat_to` to 0. A reset-pin wake or an interrupt wake leaves `stat_to`=1 and `stat_pd`=0.
- R6: `core_rst` follows the reset pin directly (high in the same cycle `rstpin_n` is low) and leaves the status bits unchanged.
- R7: While awake, a time-out with `wdt_en`=1 produces a one-cycle `core_rst` pulse in the next cycle, with `stat_to`=0 and `stat_pd`=1. With `wdt_en`=0 the time-out has no effect.
- R8: The oscillator mode is sampled at the waking event. With `osc_xtal`=1, `osc_rdy` pulses STARTUP_CYC−1 cycles after the first awake cycle. With `osc_xtal`=0, it pulses in the first awake cycle. `core_stall` stays high up to and including the `osc_rdy` cycle and is low in the next cycle.
- R9: After an interrupt wake with `gie`=1, the core gets one cycle with `core_stall`=0 for the in-line instruction, then one dummy cycle with `core_stall`=1, then one cycle with `vec_req`=1 and `core_stall`=0. After any other wake, or with `gie`=0, `vec_req` stays 0.
- R10: If an enabled interrupt flag is already set when `slp_req` arrives, the sleep strobe completes (`wdt_clr` pulse, `stat_pd`=0, `stat_to`=1) but `osc_en` never drops and the core is not stalled. The R9 sequence follows when `gie`=1.
- R11: If several wake events occur in the same sleep cycle, the reset pin wins over the watchdog, and the watchdog wins over interrupts. A reset-pin wake together with a time-out leaves `stat_to`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; it also times the start-up delay |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| slp_req | input | 1 | One-cycle sleep-instruction strobe |
| rstpin_n | input | 1 | External reset pin level, active low |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_to | input | 1 | Watchdog time-out pulse |
| gie | input | 1 | Global interrupt enable |
| irq_flag | input | N_IRQ | Interrupt source flags |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| osc_xtal | input | 1 | 1 = crystal mode (start-up delay applied), 0 = RC mode |
| osc_en | output | 1 | Oscillator driver enable |
| osc_rdy | output | 1 | One-cycle pulse when the start-up delay ends |
| core_stall | output | 1 | Holds the core's instruction flow |
| core_rst | output | 1 | Device reset request |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| stat_to | output | 1 | Time-out status bit |
| stat_pd | output | 1 | Power-down status bit |
| vec_req | output | 1 | Branch-to-interrupt-vector (0x0004) request |

## Verification
The assertions assume the following about the inputs:
- `wdt_to` is a pulse that never arrives while the time-out and reset-pin paths are expected to stay apart.
- `slp_req` arrives only while the core is running.
- `rstpin_n` does not toggle inside a start-up window except as a deliberate wake.

The bench keeps within these assumptions in two ways. It raises `slp_req` only from the running state, and it draws the wake cause, the oscillator mode, `gie`, the idle length and the ignored events from a seeded `$urandom`, applying exactly one intended wake event per sleep. Directed cases then cover the combinations the random loop avoids: a pending interrupt at the sleep strobe, a reset pin and a time-out together, and an awake time-out with the watchdog on and off.

// File: rtl/pwrdown_ctl.sv
module pwrdown_ctl #(
  parameter int N_IRQ       = 4,
  parameter int STARTUP_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slp_req,
  input  logic             rstpin_n,
  input  logic             wdt_en,
  input  logic             wdt_to,
  input  logic             gie,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             osc_xtal,
  output logic             osc_en,
  output logic             osc_rdy,
  output logic             core_stall,
  output logic             core_rst,
  output logic             wdt_clr,
  output logic             stat_to,
  output logic             stat_pd,
  output logic             vec_req
);
  localparam int CW = (STARTUP_CYC > 2) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(STARTUP_CYC - 1);

  typedef enum logic [2:0] {S_RUN, S_SLEEP, S_WARM, S_INL, S_DUM, S_VEC} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic irq_cause, clr_q, wrst_q;

  wire pend    = |(irq_flag & irq_en);
  wire pin_rst = ~rstpin_n;
  wire wdt_hit = wdt_to & wdt_en;
  wire cnt_end = (cnt == '0);

  assign osc_en     = (st != S_SLEEP);
  assign osc_rdy    = (st == S_WARM) && cnt_end;
  assign core_stall = (st == S_SLEEP) || (st == S_WARM) || (st == S_DUM);
  assign vec_req    = (st == S_VEC);
  assign core_rst   = pin_rst | wrst_q;
  assign wdt_clr    = clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      cnt       <= '0;
      irq_cause <= 1'b0;
      clr_q     <= 1'b0;
      wrst_q    <= 1'b0;
      stat_to   <= 1'b1;
      stat_pd   <= 1'b1;
    end else begin
      clr_q  <= 1'b0;
      wrst_q <= 1'b0;
      if (st == S_SLEEP) begin
        if (pin_rst || wdt_hit || pend) begin
          st        <= S_WARM;
          clr_q     <= 1'b1;
          cnt       <= osc_xtal ? LOAD : '0;
          irq_cause <= !pin_rst && !wdt_hit;
          if (!pin_rst && wdt_hit) stat_to <= 1'b0;
        end
      end else if (pin_rst) begin
        st <= S_RUN;
      end else if (wdt_hit) begin
        st      <= S_RUN;
        wrst_q  <= 1'b1;
        stat_to <= 1'b0;
        stat_pd <= 1'b1;
      end else begin
        case (st)
          S_RUN: if (slp_req) begin
            clr_q   <= 1'b1;
            stat_pd <= 1'b0;
            stat_to <= 1'b1;
            if (pend) st <= gie ? S_INL : S_RUN;
            else      st <= S_SLEEP;
          end
          S_WARM: begin
            if (cnt_end) st <= (irq_cause && gie) ? S_INL : S_RUN;
            else         cnt <= cnt - 1'b1;
          end
          S_INL:   st <= S_DUM;
          S_DUM:   st <= S_VEC;
          default: st <= S_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwrdown_ctl_chk.sv
module pwrdown_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic rstpin_n,
  input logic wdt_en,
  input logic wdt_to,
  input logic osc_en,
  input logic osc_rdy,
  input logic core_stall,
  input logic wdt_clr,
  input logic stat_to,
  input logic stat_pd,
  input logic vec_req
);
  assert_off_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> core_stall);

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (!stat_pd && stat_to && wdt_clr));

  assert_wake_clears_wdt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> wdt_clr);

  assert_wdt_wake_to_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!osc_en) && $past(rstpin_n) && $past(wdt_to && wdt_en)) |-> (osc_en && !stat_to));

  assert_rdy_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rdy |=> !core_stall);

  assert_dummy_before_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ($past(core_stall) && !core_stall));

  assert_pin_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!osc_en) && !$past(rstpin_n)) |-> (osc_en && stat_to == $past(stat_to)));
endmodule

bind pwrdown_ctl pwrdown_ctl_chk u_chk (.*);

// File: tb/sim_pwrdown_ctl.sv
`timescale 1ns/1ps
module sim_pwrdown_ctl;
  localparam int N  = 4;
  localparam int SU = 1024;

  logic clk = 0, rst_n = 0;
  logic slp_req = 0, rstpin_n = 1, wdt_en = 1, wdt_to = 0, gie = 0, osc_xtal = 1;
  logic [N-1:0] irq_flag = '0, irq_en = '0;
  logic osc_en, osc_rdy, core_stall, core_rst, wdt_clr, stat_to, stat_pd, vec_req;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwrdown_ctl #(.N_IRQ(N), .STARTUP_CYC(SU)) u0 (.*);

  function automatic int exp_wait(bit xtal);
    return xtal ? SU - 1 : 0;
  endfunction

  function automatic bit exp_to_after(int src);
    return (src == 1) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic tail(bit vec_expected);
    tick();
    chk("R8 stall released after rdy", core_stall, 0);
    if (vec_expected) begin
      chk("R9 in-line no vec", vec_req, 0);
      tick();
      chk("R9 dummy stall", core_stall, 1);
      tick();
      chk("R9 vec_req", vec_req, 1);
      chk("R9 vec no stall", core_stall, 0);
      tick();
      chk("R9 vec one cycle", vec_req, 0);
    end else begin
      bit seen = 0;
      for (int i = 0; i < 3; i++) begin
        if (vec_req) seen = 1;
        tick();
      end
      chk("R9 no vec_req", seen, 0);
    end
  endtask

  task automatic sleep_wake(int src, bit g, bit xtal, int idle);
    int n;
    bit stall_ok;
    int bit_i;
    gie = g; osc_xtal = xtal; irq_flag = '0; irq_en = '0; wdt_en = 1;
    slp_req = 1; tick(); slp_req = 0;
    chk("R2 osc off", osc_en, 0);
    chk("R2 stall", core_stall, 1);
    chk("R2 wdt_clr", wdt_clr, 1);
    chk("R2 pd", stat_pd, 0);
    chk("R2 to", stat_to, 1);
    tick();
    chk("R2 wdt_clr one cycle", wdt_clr, 0);
    for (int i = 0; i < idle; i++) begin
      wdt_en = 0; wdt_to = 1;
      irq_flag = N'($urandom); irq_en = '0; gie = ~g;
      tick();
    end
    wdt_to = 0; wdt_en = 1; irq_flag = '0; gie = g;
    chk("R3 ignored events keep sleep", osc_en, 0);
    bit_i = $urandom_range(N - 1, 0);
    case (src)
      0: rstpin_n = 0;
      1: wdt_to = 1;
      default: begin irq_flag[bit_i] = 1'b1; irq_en[bit_i] = 1'b1; end
    endcase
    tick();
    chk("R4 osc on", osc_en, 1);
    chk("R4 wdt_clr on wake", wdt_clr, 1);
    chk("R5 to after wake", stat_to, exp_to_after(src));
    chk("R5 pd after wake", stat_pd, 0);
    chk("R6 core_rst follows pin", core_rst, (src == 0) ? 1 : 0);
    rstpin_n = 1; wdt_to = 0; irq_flag = '0; irq_en = '0;
    n = 0; stall_ok = 1;
    while (!osc_rdy && n < 3000) begin
      if (!core_stall) stall_ok = 0;
      tick(); n++;
    end
    chk("R8 start-up wait", n, exp_wait(xtal));
    chk("R8 stall held", stall_ok && core_stall, 1);
    tail(src == 2 && g);
  endtask

  initial begin
    #(5.0 * 190000);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    #12 rst_n = 1; #1;
    chk("R1 to", stat_to, 1);
    chk("R1 pd", stat_pd, 1);
    chk("R1 osc", osc_en, 1);
    chk("R1 stall", core_stall, 0);
    chk("R1 vec", vec_req, 0);
    chk("R1 wdt_clr", wdt_clr, 0);
    chk("R1 core_rst", core_rst, 0);
    tick();

    sleep_wake(2, 1, 1, 2);
    sleep_wake(1, 0, 0, 1);
    sleep_wake(0, 1, 0, 0);
    for (int k = 0; k < 20; k++)
      sleep_wake($urandom_range(2, 0), 1'($urandom), 1'($urandom_range(3, 0) == 0), $urandom_range(4, 0));

    // R10 pending interrupt at the sleep strobe, gie set
    gie = 1; irq_flag = 4'b0100; irq_en = 4'b0110;
    slp_req = 1; tick(); slp_req = 0; irq_flag = '0; irq_en = '0;
    chk("R10 osc stays on", osc_en, 1);
    chk("R10 pd", stat_pd, 0);
    chk("R10 wdt_clr", wdt_clr, 1);
    chk("R10 no stall", core_stall, 0);
    tick(); chk("R10 dummy", core_stall, 1);
    tick(); chk("R10 vec", vec_req, 1);
    tick();
    // R10 with gie clear: in-line, no vector
    gie = 0; irq_flag = 4'b0001; irq_en = 4'b0001;
    slp_req = 1; tick(); slp_req = 0; irq_flag = '0; irq_en = '0;
    chk("R10 gie0 osc on", osc_en, 1);
    tail(0);

    // R11 reset pin and time-out together during sleep
    gie = 0; osc_xtal = 0;
    slp_req = 1; tick(); slp_req = 0; tick();
    rstpin_n = 0; wdt_to = 1; tick();
    chk("R11 to kept", stat_to, 1);
    chk("R11 core_rst", core_rst, 1);
    rstpin_n = 1; wdt_to = 0;
    tick(); tick(); tick();

    // R7 awake watchdog
    wdt_en = 0; wdt_to = 1; tick(); wdt_to = 0;
    chk("R7 disabled no reset", core_rst, 0);
    chk("R7 disabled to", stat_to, 1);
    wdt_en = 1; wdt_to = 1; tick(); wdt_to = 0;
    chk("R7 core_rst pulse", core_rst, 1);
    chk("R7 to cleared", stat_to, 0);
    chk("R7 pd set", stat_pd, 1);
    tick();
    chk("R7 pulse one cycle", core_rst, 0);

    // R6 pin reset while awake leaves status bits alone
    rstpin_n = 0; #1;
    chk("R6 comb core_rst", core_rst, 1);
    tick();
    chk("R6 to unchanged", stat_to, 0);
    chk("R6 pd unchanged", stat_pd, 1);
    rstpin_n = 1; tick();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule